// File: doc/BRIEF.md
# Self-Starting Five-State Sequence Counter

This block is a synchronous three-bit state machine whose state bits, called C (most significant), B and A, step through a fixed, non-binary ring of five codes: 000, 010, 011, 101, 110, and then back to 000. D-type registers hold the state. Minimized next-state equations compute the next state: A gets B and not C, B gets not B or (not A and not C), and C gets A. All three bits change on the same clock edge.

The three codes outside the ring are 001, 100 and 111. Each of them leads back into the ring, so the counter recovers from any power-up value or upset without a reset. A synchronous active-high reset returns the state to 000. A count enable steps the ring, and with the enable low the state holds. A synchronous load port writes any code, including the unused ones, so that every entry of the transition table can be reached from the ports. A status flag shows whether the present code belongs to the ring.

Top module: `seq5_counter`

## Requirements
- R1: When rst is high at a rising edge, state becomes 000 after that edge. This holds whatever the values of load_en and en.
- R2: When rst is low and load_en is high at a rising edge, state takes the value of load_code after that edge, whatever the value of en.
- R3: When rst and load_en are low and en is high, state steps along the ring 000 → 010 → 011 → 101 → 110 → 000, one code per edge.
- R4: When rst, load_en and en are all low at an edge, state keeps its value.
- R5: Unused code 001 goes to 110 on the next enabled edge.
- R6: Unused code 100 goes to 010 on the next enabled edge.
- R7: Unused code 111 goes to 100 on the next enabled edge, and then to 010 on the enabled edge after that.
- R8: in_cycle is a combinational decode of the present state. It is 1 exactly for 000, 010, 011, 101 and 110, and 0 for 001, 100 and 111.
- R9: Starting from any ring code, five enabled edges bring the state back to that same code.
- R10: From any of the eight codes, at most two enabled edges lead into the ring, and every later enabled edge keeps the state in the ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 000; highest priority |
| en | input | 1 | Count enable; advances the state one step per edge |
| load_en | input | 1 | Synchronous load strobe; ranks above en |
| load_code | input | 3 | Code written on a load, ordered {C, B, A} |
| state | output | 3 | Present state {C, B, A} |
| in_cycle | output | 1 | High when state is one of the five ring codes |

## Verification
Every state change is due one edge after the control that causes it. This applies to reset, load and step. The bench drives inputs on the falling edge and reads state 1 ns after the next rising edge, which leaves one register stage between stimulus and check. in_cycle is a decode of the registered state, so the bench checks it in the same sample as state, not one cycle later. The two-step recovery from 111 and the five-step return of the ring are counted edge by edge, with a sample after each edge.

// File: rtl/seq5_pkg.sv
package seq5_pkg;
  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] code_t;

  localparam code_t CODE_START = 3'b000;

  // Minimized next-state equations on {C,B,A}.
  function automatic code_t next_code(input code_t cur);
    logic c, b, a;
    code_t nxt;
    {c, b, a} = cur;
    nxt[0] = b & ~c;
    nxt[1] = ~b | (~a & ~c);
    nxt[2] = a;
    return nxt;
  endfunction

  // Ring membership as a sum of products: unused codes are 001, 100, 111.
  function automatic logic is_ring(input code_t cur);
    logic c, b, a;
    {c, b, a} = cur;
    return (~c & ~a) | (b & ~(c & a)) | (c & ~b & a);
  endfunction
endpackage

// File: rtl/seq5_next_logic.sv
module seq5_next_logic
  import seq5_pkg::*;
(
  input  code_t cur_code,
  output code_t nxt_code
);
  assign nxt_code = next_code(cur_code);
endmodule

// File: rtl/seq5_state_reg.sv
module seq5_state_reg
  import seq5_pkg::*;
#(
  parameter code_t RESET_CODE = CODE_START
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  load_en,
  input  code_t load_code,
  input  logic  step_en,
  input  code_t step_code,
  output code_t q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= RESET_CODE;
    else if (load_en) q <= load_code;
    else if (step_en) q <= step_code;
  end

  // Registered copy of reset for the immediate check below.
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q) assert_reset_zero_R1: assert (q == RESET_CODE);
  end
endmodule

// File: rtl/seq5_cycle_detect.sv
module seq5_cycle_detect
  import seq5_pkg::*;
(
  input  code_t cur_code,
  output logic  in_ring
);
  assign in_ring = is_ring(cur_code);
endmodule

// File: rtl/seq5_counter.sv
module seq5_counter
  import seq5_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       load_en,
  input  logic [2:0] load_code,
  output logic [2:0] state,
  output logic       in_cycle
);
  code_t cur_code;
  code_t nxt_code;
  logic  in_ring;

  // Named events for the assertions.
  logic take_load, take_step, take_hold;
  assign take_load = !rst && load_en;
  assign take_step = !rst && !load_en && en;
  assign take_hold = !rst && !load_en && !en;

  seq5_next_logic u_next (
    .cur_code (cur_code),
    .nxt_code (nxt_code)
  );

  seq5_state_reg #(.RESET_CODE(CODE_START)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_code (load_code),
    .step_en   (en),
    .step_code (nxt_code),
    .q         (cur_code)
  );

  seq5_cycle_detect u_detect (
    .cur_code (cur_code),
    .in_ring  (in_ring)
  );

  assign state    = cur_code;
  assign in_cycle = in_ring;

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    take_load |=> state == $past(load_code));

  assert_step_ring_R3: assert property (@(posedge clk) disable iff (rst)
    (take_step && in_cycle) |=> (in_cycle && state != $past(state)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    take_hold |=> $stable(state));

  assert_recover_R10: assert property (@(posedge clk) disable iff (rst)
    (take_step && !in_cycle) |=> (in_cycle || state == 3'b100));

  assert_unused_111_R7: assert property (@(posedge clk) disable iff (rst)
    (take_step && state == 3'b111) |=> state == 3'b100);
endmodule

// File: tb/tb_seq5_counter.sv
`timescale 1ns/1ps
module tb_seq5_counter;
  logic       clk = 1'b0;
  logic       rst, en, load_en;
  logic [2:0] load_code;
  logic [2:0] state;
  logic       in_cycle;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  seq5_counter dut (
    .clk(clk), .rst(rst), .en(en), .load_en(load_en),
    .load_code(load_code), .state(state), .in_cycle(in_cycle)
  );

  // Reference table written from the ring and the unused-code rules.
  function automatic logic [2:0] ref_next(input logic [2:0] s);
    case (s)
      3'b000: return 3'b010;
      3'b010: return 3'b011;
      3'b011: return 3'b101;
      3'b101: return 3'b110;
      3'b110: return 3'b000;
      3'b001: return 3'b110;
      3'b100: return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic ref_ring(input logic [2:0] s);
    return s inside {3'b000, 3'b010, 3'b011, 3'b101, 3'b110};
  endfunction

  task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s state actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in_cycle actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns after the next rising edge.
  task automatic cycle(input logic r, input logic l, input logic [2:0] code, input logic e);
    @(negedge clk);
    rst = r; load_en = l; load_code = code; en = e;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    cycle(1'b1, 1'b1, 3'b111, 1'b1);
    check3("R1", state, 3'b000);
    check1("R8", in_cycle, 1'b1);
    cycle(1'b0, 1'b1, 3'b101, 1'b0);
    cycle(1'b1, 1'b0, 3'b000, 1'b1);
    check3("R1", state, 3'b000);
  endtask

  task automatic t_table;
    for (int i = 0; i < 8; i++) begin
      cycle(1'b0, 1'b1, 3'(i), 1'b1);
      check3("R2", state, 3'(i));
      check1("R8", in_cycle, ref_ring(3'(i)));
      cycle(1'b0, 1'b0, 3'b000, 1'b1);
      if (i == 1)      check3("R5", state, ref_next(3'(i)));
      else if (i == 4) check3("R6", state, ref_next(3'(i)));
      else if (i == 7) check3("R7", state, ref_next(3'(i)));
      else             check3("R3", state, ref_next(3'(i)));
      check1("R8", in_cycle, ref_ring(ref_next(3'(i))));
    end
  endtask

  task automatic t_hold;
    cycle(1'b0, 1'b1, 3'b011, 1'b0);
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b0, 3'b110, 1'b0);
      check3("R4", state, 3'b011);
    end
    cycle(1'b0, 1'b1, 3'b111, 1'b0);
    cycle(1'b0, 1'b0, 3'b000, 1'b0);
    check3("R4", state, 3'b111);
    check1("R8", in_cycle, 1'b0);
  endtask

  task automatic t_period;
    logic [2:0] ring [5] = '{3'b000, 3'b010, 3'b011, 3'b101, 3'b110};
    for (int s = 0; s < 5; s++) begin
      cycle(1'b0, 1'b1, ring[s], 1'b0);
      for (int k = 1; k <= 5; k++) begin
        cycle(1'b0, 1'b0, 3'b000, 1'b1);
        check3("R3", state, ring[(s + k) % 5]);
      end
      check3("R9", state, ring[s]);
    end
  endtask

  task automatic t_recover;
    logic [2:0] exp;
    for (int i = 0; i < 8; i++) begin
      cycle(1'b0, 1'b1, 3'(i), 1'b0);
      exp = 3'(i);
      for (int k = 1; k <= 8; k++) begin
        cycle(1'b0, 1'b0, 3'b000, 1'b1);
        exp = ref_next(exp);
        if (k >= 2) check1("R10", in_cycle, 1'b1);
        check3("R10", state, exp);
      end
    end
    cycle(1'b0, 1'b1, 3'b111, 1'b0);
    cycle(1'b0, 1'b0, 3'b000, 1'b1);
    check3("R7", state, 3'b100);
    cycle(1'b0, 1'b0, 3'b000, 1'b1);
    check3("R7", state, 3'b010);
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; load_en = 1'b0; load_code = 3'b000;
    repeat (2) @(posedge clk);
    t_reset();
    t_table();
    t_hold();
    t_period();
    t_recover();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule